// File: doc/BRIEF.md
# Writeback slot allocator

This block hands out writeback slots to results that finish execution. Its storage is a window of `DEPTH` future cycles, and each cycle holds up to `WIDTH` ports. A result arrives as a request with a tag. The block writes the tag into the nearest future cycle that still has a free port. If that cycle is already full, the tag goes to the first later cycle that has room.

The window moves forward by one cycle on every clock. The nearest cycle group is shown on the head outputs for exactly one cycle, and after that it is gone. Up to `REQS` requests can arrive in the same cycle. They are placed one after another in index order, so each request sees the ports taken by the ones before it. A request that finds no free entry in the whole window is dropped, and a sticky overflow flag is raised.

Top module: `wb_slot_alloc`

## Requirements
- R1: After reset, head_valid is all zero, head_count is zero and overflow is low.
- R2: A request made while the window is empty shows up in the next cycle on head port 0 (head_valid bit 0), carrying its tag on head_tag bits [TAG_W-1:0].
- R3: No cycle group holds more than WIDTH entries. A request whose nearest cycle is full goes to the first later cycle that has a free port.
- R4: Requests in one cycle are placed in ascending index order. A lower index never gets a later cycle, or a higher port in the same cycle, than a higher index.
- R5: Ports in a cycle group are filled from port 0 upward, so head_valid is always a contiguous run of ones starting at bit 0.
- R6: head_count always equals the number of set bits in head_valid.
- R7: The window moves forward every clock. A group is on the head outputs for exactly one cycle, and every later group moves one cycle closer.
- R8: The search starts at the nearest cycle and port 0 in every cycle, whatever the earlier cycles placed.
- R9: When all WIDTH*DEPTH entries of the coming window are occupied, a request is dropped and overflow goes high. Overflow stays high until reset.
- R10: In the cycle after any request, head_valid bit 0 or overflow is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | REQS | One valid bit per request lane; lane 0 has the highest placement priority |
| req_tag | input | REQS*TAG_W | Tags; lane r uses bits [r*TAG_W +: TAG_W] |
| head_valid | output | WIDTH | Valid bit per port of the cycle group now at the head |
| head_tag | output | WIDTH*TAG_W | Tags of the head group; port p uses bits [p*TAG_W +: TAG_W] |
| head_count | output | $clog2(WIDTH+1) | Occupancy count of the head group |
| overflow | output | 1 | Sticky flag: a request found no free entry |

## Verification
The bench drives bursts that fill the nearest cycle past WIDTH. A design that kept the search on one cycle would then overwrite or lose tags, and a design that gave later lanes priority would swap tag order on the head. Sparse lane patterns such as lanes 0 and 2 only would catch a design that packs by lane index instead of by arrival order. A sustained overload runs the window to capacity. A design without the capacity check would wrap into the head or corrupt data, and a non-sticky flag would drop low during the drain that follows. A single request after far slots have been filled catches a search pointer that carries over from the previous cycle.

// File: rtl/wb_slot_alloc.sv
module wb_slot_alloc #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 4,
  parameter int TAG_W = 8,
  parameter int REQS  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [REQS-1:0]            req_valid,
  input  logic [REQS*TAG_W-1:0]      req_tag,
  output logic [WIDTH-1:0]           head_valid,
  output logic [WIDTH*TAG_W-1:0]     head_tag,
  output logic [$clog2(WIDTH+1)-1:0] head_count,
  output logic                       overflow
);
  localparam int SLOTS = WIDTH * DEPTH;
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic [SLOTS-1:0]       vld_q, vld_n;
  logic [SLOTS*TAG_W-1:0] tag_q, tag_n;
  logic [DEPTH*CNT_W-1:0] cnt_q, cnt_n;
  logic                   ovf_n;
  logic                   placed;

  always_comb begin
    vld_n  = vld_q >> WIDTH;
    tag_n  = tag_q >> (WIDTH * TAG_W);
    cnt_n  = cnt_q >> CNT_W;
    ovf_n  = overflow;
    placed = 1'b0;
    for (int r = 0; r < REQS; r++) begin
      placed = 1'b0;
      if (req_valid[r]) begin
        for (int k = 0; k < SLOTS; k++) begin
          if (!placed && !vld_n[k]) begin
            vld_n[k] = 1'b1;
            tag_n[k*TAG_W +: TAG_W] = req_tag[r*TAG_W +: TAG_W];
            cnt_n[(k/WIDTH)*CNT_W +: CNT_W] = cnt_n[(k/WIDTH)*CNT_W +: CNT_W] + CNT_W'(1);
            placed = 1'b1;
          end
        end
        if (!placed) ovf_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= '0;
      tag_q    <= '0;
      cnt_q    <= '0;
      overflow <= 1'b0;
    end else begin
      vld_q    <= vld_n;
      tag_q    <= tag_n;
      cnt_q    <= cnt_n;
      overflow <= ovf_n;
    end
  end

  assign head_valid = vld_q[WIDTH-1:0];
  assign head_tag   = tag_q[WIDTH*TAG_W-1:0];
  assign head_count = cnt_q[CNT_W-1:0];
endmodule

// File: rtl/wb_slot_alloc_chk.sv
module wb_slot_alloc_chk #(
  parameter int WIDTH = 2,
  parameter int REQS  = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [REQS-1:0]            req_valid,
  input logic [WIDTH-1:0]           head_valid,
  input logic [$clog2(WIDTH+1)-1:0] head_count,
  input logic                       overflow
);
  a_r5_head_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    ((head_valid + 1'b1) & head_valid) == '0);

  a_r6_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    int'(head_count) == $countones(head_valid));

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r10_request_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_valid) |=> (head_valid[0] || overflow));
endmodule

bind wb_slot_alloc wb_slot_alloc_chk #(.WIDTH(WIDTH), .REQS(REQS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .head_valid(head_valid), .head_count(head_count), .overflow(overflow));

// File: tb/wb_slot_alloc_test.sv
`timescale 1ns/1ps
module wb_slot_alloc_test;
  localparam int W = 2, D = 4, TW = 8, RQ = 3;

  logic clk = 0, rst_n = 0;
  logic [RQ-1:0] req_valid = '0;
  logic [RQ*TW-1:0] req_tag = '0;
  logic [W-1:0] head_valid;
  logic [W*TW-1:0] head_tag;
  logic [$clog2(W+1)-1:0] head_count;
  logic overflow;

  wb_slot_alloc #(.WIDTH(W), .DEPTH(D), .TAG_W(TW), .REQS(RQ)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .head_valid(head_valid), .head_tag(head_tag), .head_count(head_count),
    .overflow(overflow));

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  int mq[D][$];
  bit m_ovf = 0;
  int next_tag = 1;
  bit prev_req = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare(string lbl);
    for (int p = 0; p < W; p++) begin
      bit ev = p < mq[0].size();
      chk(head_valid[p] == ev, {lbl, " head_valid"}, int'(head_valid[p]), int'(ev));
      if (ev) chk(int'(head_tag[p*TW +: TW]) == mq[0][p], {lbl, " head_tag"},
                  int'(head_tag[p*TW +: TW]), mq[0][p]);
    end
    chk(int'(head_count) == mq[0].size(), "R6 head_count", int'(head_count), mq[0].size());
    chk(((head_valid + 1'b1) & head_valid) == '0, "R5 contiguous", int'(head_valid), 0);
    chk(overflow == m_ovf, "R9 overflow", int'(overflow), int'(m_ovf));
    if (prev_req) chk(head_valid[0] || overflow, "R10 landing", int'(head_valid[0]), 1);
  endtask

  task automatic step(logic [RQ-1:0] v, string lbl);
    compare(lbl);
    req_valid = v;
    for (int d = 0; d < D - 1; d++) mq[d] = mq[d+1];
    mq[D-1] = {};
    for (int r = 0; r < RQ; r++) begin
      req_tag[r*TW +: TW] = v[r] ? TW'(next_tag) : '0;
      if (v[r]) begin
        bit placed = 0;
        for (int d = 0; d < D; d++)
          if (!placed && mq[d].size() < W) begin
            mq[d].push_back(next_tag);
            placed = 1;
          end
        if (!placed) m_ovf = 1;
        next_tag = (next_tag % 255) + 1;
      end
    end
    prev_req = |v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    req_valid = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int d = 0; d < D; d++) mq[d] = {};
    m_ovf = 0;
    prev_req = 0;
  endtask

  initial begin
    do_reset();
    chk(head_valid == '0 && head_count == 0 && !overflow, "R1 reset", int'(head_valid), 0);
    step(3'b001, "R1");
    step(3'b000, "R2 single");
    step(3'b000, "R7 drop");
    step(3'b111, "R7");
    step(3'b000, "R3 spill");
    step(3'b000, "R3 spill");
    step(3'b101, "R7");
    step(3'b010, "R4 order");
    step(3'b110, "R4 order");
    step(3'b000, "R4 order");
    step(3'b000, "R7");
    step(3'b111, "R8");
    step(3'b111, "R8");
    step(3'b001, "R8");
    step(3'b000, "R8 nearest");
    for (int i = 0; i < 8; i++) step(3'b000, "R7 drain");
    for (int i = 0; i < 12; i++) step(3'b111, "R9 fill");
    for (int i = 0; i < 8; i++) step(3'b000, "R9 sticky");
    step(3'b000, "R9");
    do_reset();
    chk(head_valid == '0 && head_count == 0 && !overflow, "R1 rereset", int'(overflow), 0);
    for (int i = 0; i < 20; i++) step(RQ'(i % 8), "R3 mix");
    for (int i = 0; i < 6; i++) step(3'b000, "R7 end");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule